// File: doc/BRIEF.md
# Timer Time-Base with Repetition-Gated Update

This block is the counting core of a general-purpose timer. A prescaler divides the clock into count ticks. A 16-bit main counter counts up, counts down, or counts up and down in turn (center-aligned) between zero and an active period value. An 8-bit repetition counter sits between the counter's wrap points and the update event. An update fires only when the repetition counter is at zero as a wrap occurs. The repetition counter then reloads, so an update arrives once every REP+1 wraps.

Period, prescale divisor and one compare value are written into preload registers. They move into the active shadow copies only when an update fires. New settings therefore take effect on a clean period boundary. The period can instead be written straight into the active copy when period buffering is off. Software can force an update at once through an event strobe, and so can an external trigger input. A forced update also restarts the prescaler, the main counter and the repetition counter. Every update raises a sticky flag that software clears by a register write.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count is 0, the update pulse and flag are 0, and the active compare value is 0. The active period and the period preload reset to 0xFFFF. The prescale and repetition values reset to 0.
- R2: Register map, selected by wr_addr: 0 = control (bit0 count enable, bits[2:1] mode, bit3 period buffering), 1 = period, 2 = prescale, 3 = repetition, 4 = compare, 5 = event (bit0 = force update), 6 = flag clear (bit0). While enabled, the counter takes one step every PSC+1 clocks. With enable at 0 it holds its value.
- R3: Mode 0 (up): the count rises by one per tick. At a tick where the count is at or above the active period, it wraps to 0 and a wrap is recorded.
- R4: Mode 1 (down): the count falls by one per tick. At a tick where it is 0, it reloads and a wrap is recorded. The reload value is the newly loaded period when this wrap fires an update, and otherwise the active period.
- R5: Modes 2 and 3 (center): the count rises to the active period and then falls to 0. The turn at the top and the turn at the bottom each count as a wrap. With period 3 and prescale 0 the sequence after a restart is 1,2,3,2,1,0,1,…
- R6: A wrap fires an update only when the repetition counter is 0, and then reloads that counter from the repetition register. Otherwise the wrap decrements it. An update therefore occurs once every REP+1 wraps.
- R7: On every update, the period, prescale and compare preloads are copied into the active registers. With buffering on, a period write leaves the active period unchanged until the next update. The active compare value changes only at an update.
- R8: With buffering off, a period write changes the active period in the next cycle.
- R9: A force (event bit0 write, or trig_in high) fires an update whatever the repetition count. It reloads the repetition counter, clears the prescaler and restarts the count: at the newly loaded period in mode 1, and at 0 in the other modes, with center counting rising.
- R10: Each update sets uif_o, which stays set until a flag-clear write. An update in the same cycle as a clear leaves the flag set.
- R11: upd_o is high for exactly one cycle per update. It appears in the cycle after the edge that performed the update, together with the new count and the new compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External force-update trigger, active high |
| cnt_o | output | 16 | Current count |
| upd_o | output | 1 | Update event pulse |
| uif_o | output | 1 | Sticky update flag |
| cmp_o | output | 16 | Active compare value |

## Verification
The bench counts update pulses across a window of repetition-gated wraps. A design that updated on every wrap, or that failed to reload its repetition counter, would show more pulses than expected. It writes a new period and compare value with buffering on. It then checks that the old period bounds the count until the update and the new one bounds it afterwards. An unbuffered design would jump early. Center mode is walked tick by tick to catch an off-by-one at the turning points, or a missing decrement on one of the two wraps. Down-mode restart and reload values, and a trigger that arrives together with a flag clear, are checked directly. A reference model is compared against every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_CTR  = 2'd2,
    MODE_CTR2 = 2'd3
  } cmode_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_PER  = 3'd1;
  localparam logic [2:0] ADDR_PSC  = 3'd2;
  localparam logic [2:0] ADDR_REP  = 3'd3;
  localparam logic [2:0] ADDR_CMP  = 3'd4;
  localparam logic [2:0] ADDR_EVT  = 3'd5;
  localparam logic [2:0] ADDR_CLR  = 3'd6;

  function automatic logic is_center(cmode_e m);
    return (m == MODE_CTR) || (m == MODE_CTR2);
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             upd_evt,
  output logic             cen,
  output cmode_e           mode,
  output logic             arpe,
  output logic [CNT_W-1:0] per_pre,
  output logic [CNT_W-1:0] per_act,
  output logic [PSC_W-1:0] psc_act,
  output logic [REP_W-1:0] rep_val,
  output logic [CNT_W-1:0] cmp_act,
  output logic             ug,
  output logic             clr
);

  localparam logic [CNT_W-1:0] PER_RST = '1;

  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] cmp_pre;
  logic             wr_ctrl, wr_per, wr_psc, wr_rep, wr_cmp;
  logic [CNT_W-5:0] ctrl_spare;

  assign wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_per     = wr_en && (wr_addr == ADDR_PER);
  assign wr_psc     = wr_en && (wr_addr == ADDR_PSC);
  assign wr_rep     = wr_en && (wr_addr == ADDR_REP);
  assign wr_cmp     = wr_en && (wr_addr == ADDR_CMP);
  assign ug         = wr_en && (wr_addr == ADDR_EVT) && wr_data[0];
  assign clr        = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
  assign ctrl_spare = wr_data[CNT_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen  <= 1'b0;
      mode <= MODE_UP;
      arpe <= 1'b0;
    end else if (wr_ctrl) begin
      cen  <= wr_data[0];
      mode <= cmode_e'(wr_data[2:1]);
      arpe <= wr_data[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_pre <= PER_RST;
      per_act <= PER_RST;
    end else begin
      if (wr_per) per_pre <= wr_data;
      if (wr_per && !arpe) per_act <= wr_data;
      else if (upd_evt)    per_act <= per_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      psc_act <= '0;
      cmp_pre <= '0;
      cmp_act <= '0;
      rep_val <= '0;
    end else begin
      if (wr_psc) psc_pre <= wr_data[PSC_W-1:0];
      if (wr_cmp) cmp_pre <= wr_data;
      if (wr_rep) rep_val <= wr_data[REP_W-1:0];
      if (upd_evt) begin
        psc_act <= psc_pre;
        cmp_act <= cmp_pre;
      end
    end
  end

  // R7: active compare moves only at an update
  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(cmp_act));

  // R7: buffered period ignores writes until an update
  p_per_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arpe && !upd_evt) |=> $stable(per_act));

  // R8: unbuffered period write lands at once
  p_per_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_per && !arpe) |=> (per_act == $past(wr_data)));

  // R2: spare control bits are accepted and ignored
  p_spare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (ctrl_spare != '0)) |=> (cen == $past(wr_data[0])));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             force_upd,
  input  logic [PSC_W-1:0] psc_act,
  output logic             tick
);

  logic [PSC_W-1:0] div_q;

  assign tick = cen && !force_upd && (div_q >= psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (force_upd) div_q <= '0;
    else if (cen)       div_q <= tick ? '0 : div_q + 1'b1;
  end

  // R2: divider restarts after every tick
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (div_q == '0));

  // R9: a force clears the divider
  p_force_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (div_q == '0));

  // R2: divider frozen while disabled
  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !force_upd) |=> $stable(div_q));

endmodule

// File: rtl/tmr_repcnt.sv
module tmr_repcnt #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             force_upd,
  input  logic [REP_W-1:0] rep_val,
  output logic             upd_evt
);

  logic [REP_W-1:0] rep_q;
  logic             expire;

  assign expire  = wrap && (rep_q == '0);
  assign upd_evt = force_upd || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rep_q <= '0;
    else if (force_upd || expire)  rep_q <= rep_val;
    else if (wrap)                 rep_q <= rep_q - 1'b1;
  end

  // R6: non-final wrap decrements without an update
  p_rep_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !force_upd && (rep_q != '0)) |=> (rep_q == $past(rep_q) - 1'b1));

  // R6: expiry reloads from the repetition register
  p_rep_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rep_q == $past(rep_val)));

  // R9: force reloads regardless of the current count
  p_rep_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (rep_q == $past(rep_val)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             upd_evt,
  input  cmode_e           mode,
  input  logic [CNT_W-1:0] per_act,
  input  logic [CNT_W-1:0] per_pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dir_dn_q, dir_dn_nx;
  logic [CNT_W-1:0] cnt_nx;

  function automatic logic [CNT_W-1:0] dec_sat(logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    cnt_nx    = cnt;
    dir_dn_nx = dir_dn_q;
    wrap      = 1'b0;
    if (force_upd) begin
      cnt_nx    = (mode == MODE_DOWN) ? per_pre : '0;
      dir_dn_nx = 1'b0;
    end else if (tick) begin
      if (mode == MODE_UP) begin
        if (cnt >= per_act) begin
          cnt_nx = '0;
          wrap   = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else if (mode == MODE_DOWN) begin
        if (cnt == '0) begin
          wrap   = 1'b1;
          cnt_nx = upd_evt ? per_pre : per_act;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end else if (!dir_dn_q) begin
        if (cnt >= per_act) begin
          wrap      = 1'b1;
          dir_dn_nx = 1'b1;
          cnt_nx    = dec_sat(cnt);
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          wrap      = 1'b1;
          dir_dn_nx = 1'b0;
          cnt_nx    = (per_act == '0) ? '0 : ONE;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_dn_q <= 1'b0;
    end else begin
      cnt      <= cnt_nx;
      dir_dn_q <= dir_dn_nx;
    end
  end

  // R2: no tick, no force -> count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_upd) |=> $stable(cnt));

  // R3: up mode wraps to zero
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_upd && (mode == MODE_UP) && (cnt >= per_act)) |=> (cnt == '0));

  // R4: down mode without update reloads the active period
  p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_upd && !upd_evt && (mode == MODE_DOWN) && (cnt == '0))
      |=> (cnt == $past(per_act)));

  // R5: the top turn heads down
  p_ctr_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !force_upd && is_center(mode) && !dir_dn_q && (cnt >= per_act) && (cnt != '0))
      |=> (dir_dn_q && (cnt == $past(cnt) - ONE)));

  // R9: restart position after a force
  p_force_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt == (($past(mode) == MODE_DOWN) ? $past(per_pre) : '0)));

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o,
  output logic             uif_o,
  output logic [CNT_W-1:0] cmp_o
);

  logic             cen, arpe, ug, clr;
  cmode_e           mode;
  logic [CNT_W-1:0] per_pre, per_act;
  logic [PSC_W-1:0] psc_act;
  logic [REP_W-1:0] rep_val;
  logic             force_upd, tick, wrap, upd_evt;

  assign force_upd = ug || trig_in;

  tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_evt(upd_evt), .cen(cen), .mode(mode), .arpe(arpe), .per_pre(per_pre),
    .per_act(per_act), .psc_act(psc_act), .rep_val(rep_val), .cmp_act(cmp_o),
    .ug(ug), .clr(clr)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .cen(cen), .force_upd(force_upd),
    .psc_act(psc_act), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd), .upd_evt(upd_evt),
    .mode(mode), .per_act(per_act), .per_pre(per_pre), .cnt(cnt_o), .wrap(wrap)
  );

  tmr_repcnt #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .force_upd(force_upd),
    .rep_val(rep_val), .upd_evt(upd_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_o <= 1'b0;
      uif_o <= 1'b0;
    end else begin
      upd_o <= upd_evt;
      if (upd_evt)  uif_o <= 1'b1;
      else if (clr) uif_o <= 1'b0;
    end
  end

  // R10: the flag is set whenever a pulse is visible
  p_uif_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> uif_o);

  // R10: the flag only drops after a clear write
  p_uif_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uif_o) |-> $past(clr));

  // R9: a force always yields a pulse next cycle
  p_force_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> upd_o);

  // R11: a pulse needs an update source
  p_pulse_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> ($past(force_upd) || $past(wrap)));

endmodule

// File: tb/tmr_timebase_tb.sv
`timescale 1ns/1ps
module tmr_timebase_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        trig_in = 1'b0;
  logic [15:0] cnt_o, cmp_o;
  logic        upd_o, uif_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tmr_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .cnt_o(cnt_o), .upd_o(upd_o), .uif_o(uif_o), .cmp_o(cmp_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_div = 0, m_rep = 0, m_dir = 0;
  int m_per_p = 65535, m_per_a = 65535, m_psc_p = 0, m_psc_a = 0;
  int m_cmp_p = 0, m_cmp_a = 0, m_rcr = 0, m_cen = 0, m_mode = 0, m_buf = 0;
  bit m_upd = 0, m_uif = 0;

  task automatic do_update();
    m_per_a = m_per_p;
    m_psc_a = m_psc_p;
    m_cmp_a = m_cmp_p;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_rep = 0; m_dir = 0;
      m_per_p = 65535; m_per_a = 65535; m_psc_p = 0; m_psc_a = 0;
      m_cmp_p = 0; m_cmp_a = 0; m_rcr = 0; m_cen = 0; m_mode = 0; m_buf = 0;
      m_upd = 0; m_uif = 0;
    end else begin
      bit frc, upd, wrapped, clear;
      int old_per;
      frc = (wr_en && wr_addr == 3'd5 && wr_data[0]) || trig_in;
      clear = wr_en && wr_addr == 3'd6 && wr_data[0];
      upd = 0; wrapped = 0;
      old_per = m_per_a;
      if (frc) begin
        upd = 1;
        m_rep = m_rcr; m_div = 0; m_dir = 0;
        m_cnt = (m_mode == 1) ? m_per_p : 0;
        do_update();
      end else if (m_cen) begin
        if (m_div >= m_psc_a) begin
          m_div = 0;
          if (m_mode == 0) begin
            if (m_cnt >= m_per_a) begin m_cnt = 0; wrapped = 1; end
            else m_cnt++;
          end else if (m_mode == 1) begin
            if (m_cnt == 0) wrapped = 1; else m_cnt--;
          end else if (m_dir == 0) begin
            if (m_cnt >= m_per_a) begin
              wrapped = 1; m_dir = 1; if (m_cnt > 0) m_cnt--;
            end else m_cnt++;
          end else begin
            if (m_cnt == 0) begin
              wrapped = 1; m_dir = 0; m_cnt = (m_per_a == 0) ? 0 : 1;
            end else m_cnt--;
          end
          if (wrapped) begin
            if (m_rep == 0) begin upd = 1; m_rep = m_rcr; end
            else m_rep--;
          end
          if (wrapped && m_mode == 1) m_cnt = upd ? m_per_p : old_per;
          if (upd) do_update();
        end else m_div++;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_cen = wr_data[0]; m_mode = wr_data[2:1]; m_buf = wr_data[3]; end
          3'd1: begin m_per_p = wr_data; if (!m_buf) m_per_a = wr_data; end
          3'd2: m_psc_p = wr_data;
          3'd3: m_rcr = wr_data[7:0];
          3'd4: m_cmp_p = wr_data;
          default: ;
        endcase
      end
      if (upd) m_uif = 1; else if (clear) m_uif = 0;
      m_upd = upd;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (cnt_o != m_cnt[15:0] || upd_o != m_upd || uif_o != m_uif || cmp_o != m_cmp_a[15:0]) begin
        n_fail++;
        $display("FAIL model compare (R2 R3 R4 R5 R6 R7 R9 R10 R11) @%0t: cnt/upd/uif/cmp act %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
                 $time, cnt_o, upd_o, uif_o, cmp_o, m_cnt, m_upd, m_uif, m_cmp_a);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  initial begin
    int pulses, maxc;
    bit seen;
    int exp_seq [12] = '{1, 2, 3, 2, 1, 0, 1, 2, 3, 2, 1, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cnt", cnt_o, 0);
    check("R1 upd", upd_o, 0);
    check("R1 uif", uif_o, 0);
    check("R1 cmp", cmp_o, 0);

    wr(3'd2, 16'd1);
    wr(3'd1, 16'd4);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd7);
    wr(3'd0, 16'h0008);              // up, buffered, disabled
    check("R7 cmp before update", cmp_o, 0);
    wr(3'd5, 16'd1);                 // force
    check("R9 forced pulse", upd_o, 1);
    check("R7 cmp copied", cmp_o, 7);
    check("R10 flag set", uif_o, 1);
    @(negedge clk);
    check("R11 pulse one cycle", upd_o, 0);
    wr(3'd6, 16'd1);
    check("R10 flag cleared", uif_o, 0);
    repeat (6) @(negedge clk);
    check("R2 hold while disabled", cnt_o, 0);

    // R6 repetition gating, up mode
    wr(3'd3, 16'd2);
    wr(3'd0, 16'h0009);
    wr(3'd5, 16'd1);
    pulses = 0; maxc = 0;
    for (int i = 0; i < 145; i++) begin
      @(negedge clk);
      if (upd_o) pulses++;
      if (cnt_o > maxc) maxc = cnt_o;
    end
    check("R6 updates every REP+1 wraps", pulses, 4);
    check("R3 up count peak", maxc, 4);

    // R7 buffered period and compare
    wr(3'd1, 16'd9);
    wr(3'd4, 16'd5);
    check("R7 cmp held until update", cmp_o, 7);
    maxc = 0; seen = 0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (upd_o) seen = 1;
      else if (cnt_o > maxc) maxc = cnt_o;
    end
    check("R7 old period until update", maxc, 4);
    check("R7 update reached", seen, 1);
    check("R7 new cmp active", cmp_o, 5);
    maxc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cnt_o > maxc) maxc = cnt_o;
    end
    check("R7 new period active", maxc, 9);

    // R8 unbuffered period
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd2);
    repeat (4) @(negedge clk);
    maxc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cnt_o > maxc) maxc = cnt_o;
    end
    check("R8 immediate period", maxc, 2);

    // R9 external trigger, R10 set wins over clear
    wr(3'd6, 16'd1);
    repeat (3) @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
    check("R9 trigger pulse", upd_o, 1);
    check("R9 trigger restart", cnt_o, 0);
    trig_in = 1'b1;
    wr(3'd6, 16'd1);
    trig_in = 1'b0;
    check("R10 set wins over clear", uif_o, 1);

    // R4 down mode
    wr(3'd0, 16'h0003);
    wr(3'd5, 16'd1);
    check("R9 down restart at period", cnt_o, 2);
    repeat (4) @(negedge clk);
    check("R4 down reaches zero", cnt_o, 0);
    repeat (2) @(negedge clk);
    check("R4 down reload", cnt_o, 2);

    // R5 center mode
    wr(3'd2, 16'd0);
    wr(3'd1, 16'd3);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0005);
    wr(3'd5, 16'd1);
    check("R5 center start", cnt_o, 0);
    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R5 center sequence", cnt_o, exp_seq[i]);
      if (upd_o) pulses++;
    end
    check("R5 both turns count as wraps", pulses, 3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule